// File: doc/BRIEF.md
# Paced Serial Nibble Transmitter

This block shifts 4-bit groups out over one shared, open-drain data wire. The receiving side sets the pace. Before each bit the transmitter waits until it sees the wire high. It then puts the bit on the wire for a fixed number of clocks. After that it lets go of the wire for the same number of clocks, so the wire is back high before the next bit, or before the end.

The transmitter never drives the wire high. A one is sent by leaving the wire released. A zero is sent by pulling the wire low. The wire is read back only through a synchronizer.

A host starts a transfer with a one-clock strobe. A mode input chooses between two transfers:
- Nibble mode sends the low four bits of the data word.
- Pair mode sends the full 8-bit word as two back-to-back nibbles, upper nibble first.

A busy level covers the whole transfer. A one-clock done pulse marks its end.

Top module: `nibble_serial_tx`

## Requirements
- R1: While reset is held and right after it is released, `line_pull_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: The pull-down of a bit never begins while the synchronized wire reads low. A transfer whose wire is held low by the peer stays busy and does not pull.
- R3: Each nibble is sent most significant bit first, exactly four bits. In nibble mode (`pair_mode_i` = 0) the bits sent are `data_i[3]`, `data_i[2]`, `data_i[1]`, `data_i[0]`.
- R4: A 0 bit sets `line_pull_o` to 1 for exactly HOLD_CLKS cycles. A 1 bit leaves `line_pull_o` at 0 for the whole bit.
- R5: After each bit level the wire is released for HOLD_CLKS cycles before the next poll. With the wire high, the bit period is 1 + 2·HOLD_CLKS cycles. Bit k's level starts on the edge 1 + k·(1 + 2·HOLD_CLKS) after the start edge.
- R6: In pair mode (`pair_mode_i` = 1) the eight bits `data_i[7]` down to `data_i[0]` go out as two consecutive nibbles, with no idle cycle between them.
- R7: `busy_o` is 1 from the cycle after the accepted start until the last release completes. `done_o` is 1 for exactly one cycle, the cycle in which `busy_o` has just returned to 0.
- R8: While busy, a start strobe is ignored, and so are changes on `data_i` and `pair_mode_i`. The word and mode in flight are those captured at the accepted start.
- R9: The wire passes through SYNC_STAGES flip-flops. When a held-low wire is released, the first pull of a 0 bit appears SYNC_STAGES + 1 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that launches a transfer when idle |
| pair_mode_i | input | 1 | 1: send 8 bits as two nibbles; 0: send `data_i[3:0]` |
| data_i | input | 2·NIB_W | Word to send, captured on the accepted start |
| line_i | input | 1 | Raw level read back from the shared wire |
| line_pull_o | output | 1 | 1 enables the open-drain pull-down of the wire |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after the last bit's release |

## Verification
The hardest situation to reach from the ports is a peer that holds the wire low while the transmitter is waiting to send. This must stall the transfer without any pull, and the release must then be picked up exactly after the synchronizer latency.

The bench makes its peer pull the wire low before a start, keeps it there for tens of cycles, and lets go on a known edge. It then checks the edge on which the first zero bit appears.

A second hard case is a start strobe, with new data, that arrives in the middle of a transfer. Random transfers inject such a strobe at a random cycle, and the bench confirms that the bit stream and the end of busy are unchanged.

// File: rtl/nts_pkg.sv
package nts_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_WAIT_HI = 2'd1,
      ST_DRIVE   = 2'd2,
      ST_RELEASE = 2'd3
   } tx_state_e;
endpackage

// File: rtl/nts_line_sync.sv
module nts_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("nts_line_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= pin_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/nts_hold_timer.sv
module nts_hold_timer #(
   parameter int HOLD_CLKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic end_o
);
   localparam int HOLD_W = $clog2(HOLD_CLKS + 1);

   logic [HOLD_W-1:0] cnt_q;

   generate
      if (HOLD_CLKS < 1) begin : g_bad_hold
         $error("nts_hold_timer: HOLD_CLKS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (en_i)  cnt_q <= cnt_q + HOLD_W'(1);
   end

   assign end_o = en_i && (cnt_q == HOLD_W'(HOLD_CLKS - 1));

   // R5
   hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < HOLD_W'(HOLD_CLKS));
endmodule

// File: rtl/nts_nibble_shifter.sv
module nts_nibble_shifter #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               pair_i,
   input  logic [2*NIB_W-1:0] data_i,
   input  logic               step_i,
   output logic               msb_o,
   output logic               final_o
);
   localparam int CNT_W = $clog2(NIB_W + 1);

   logic [NIB_W-1:0] work_q, spare_q;
   logic [CNT_W-1:0] left_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q  <= '0;
         spare_q <= '0;
         left_q  <= '0;
         pend_q  <= 1'b0;
      end else if (load_i) begin
         left_q <= CNT_W'(NIB_W);
         if (pair_i) begin
            work_q  <= data_i[2*NIB_W-1:NIB_W];
            spare_q <= data_i[NIB_W-1:0];
            pend_q  <= 1'b1;
         end else begin
            work_q  <= data_i[NIB_W-1:0];
            spare_q <= '0;
            pend_q  <= 1'b0;
         end
      end else if (step_i) begin
         if (left_q == CNT_W'(1) && pend_q) begin
            work_q <= spare_q;
            left_q <= CNT_W'(NIB_W);
            pend_q <= 1'b0;
         end else begin
            work_q <= work_q << 1;
            left_q <= left_q - CNT_W'(1);
         end
      end
   end

   assign msb_o   = work_q[NIB_W-1];
   assign final_o = (left_q == CNT_W'(1)) && !pend_q;

   // R3
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= CNT_W'(NIB_W));
   // R3
   step_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (left_q != '0));
endmodule

// File: rtl/nibble_serial_tx.sv
module nibble_serial_tx
   import nts_pkg::*;
#(
   parameter int NIB_W       = 4,
   parameter int HOLD_CLKS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               pair_mode_i,
   input  logic [2*NIB_W-1:0] data_i,
   input  logic               line_i,
   output logic               line_pull_o,
   output logic               busy_o,
   output logic               done_o
);
   generate
      if (NIB_W < 1) begin : g_bad_nib
         $error("nibble_serial_tx: NIB_W must be at least 1");
      end
      if (HOLD_CLKS <= SYNC_STAGES) begin : g_bad_hold
         $error("nibble_serial_tx: HOLD_CLKS must exceed SYNC_STAGES");
      end
   endgenerate

   tx_state_e state_q, state_nx;
   logic      line_hi, hold_end, hold_en, hold_clr;
   logic      bit_msb, last_bit, load, step;
   logic      pull_nx, done_nx;

   nts_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(line_i), .level_o(line_hi));

   nts_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr_i(hold_clr), .en_i(hold_en), .end_o(hold_end));

   nts_nibble_shifter #(.NIB_W(NIB_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(load), .pair_i(pair_mode_i),
      .data_i(data_i), .step_i(step), .msb_o(bit_msb), .final_o(last_bit));

   assign hold_en  = (state_q == ST_DRIVE) || (state_q == ST_RELEASE);
   assign hold_clr = !hold_en || hold_end;
   assign load     = (state_q == ST_IDLE) && start_i;
   assign step     = (state_q == ST_RELEASE) && hold_end;

   always_comb begin
      state_nx = state_q;
      pull_nx  = line_pull_o;
      done_nx  = 1'b0;
      case (state_q)
         ST_IDLE: if (start_i) state_nx = ST_WAIT_HI;
         ST_WAIT_HI:
            if (line_hi) begin
               state_nx = ST_DRIVE;
               pull_nx  = !bit_msb;
            end
         ST_DRIVE:
            if (hold_end) begin
               state_nx = ST_RELEASE;
               pull_nx  = 1'b0;
            end
         ST_RELEASE:
            if (hold_end) begin
               state_nx = last_bit ? ST_IDLE : ST_WAIT_HI;
               done_nx  = last_bit;
            end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         line_pull_o <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         state_q     <= state_nx;
         line_pull_o <= pull_nx;
         done_o      <= done_nx;
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   // R4
   pull_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_pull_o |-> busy_o);
   // R2
   wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_HI && !line_hi) |=> !line_pull_o);
   // R2
   pull_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_o) |-> $past(line_hi));
   // R5
   release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RELEASE) |-> !line_pull_o);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !step) |=> busy_o);
endmodule

// File: tb/tb_nibble_serial_tx.sv
module tb_nibble_serial_tx;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 8;
   localparam int SYNC       = 2;
   localparam int PER        = 1 + 2 * HOLD;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       pair = 1'b0;
   logic [7:0] data = 8'h00;
   logic       peer_low = 1'b0;
   logic       pull, busy, done;
   logic       line;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   assign line = !pull && !peer_low;

   nibble_serial_tx #(.NIB_W(4), .HOLD_CLKS(HOLD), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .pair_mode_i(pair),
      .data_i(data), .line_i(line), .line_pull_o(pull),
      .busy_o(busy), .done_o(done));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_bit(input logic [7:0] d, input bit pr, input int k);
      return pr ? d[7-k] : d[3-k];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // Cycle c is the cycle after the c-th edge following the start edge.
   task automatic run_xfer(input logic [7:0] d, input bit pr, input int inject, input string tag);
      int nb   = pr ? 8 : 4;
      int last = nb * PER;
      int bad_p = -1, bad_b = -1, bad_d = -1;
      int ap = 0, ep = 0, ab = 0, eb = 0, ad = 0, ed = 0;
      @(negedge clk);
      data = d; pair = pr; start = 1'b1;
      for (int c = 0; c <= last + 1; c++) begin
         bit e_pull, e_busy, e_done;
         @(negedge clk);
         if (c == 0 || c == inject + 1) start = 1'b0;
         e_pull = 1'b0;
         if (c >= 1 && c <= last)
            e_pull = (((c - 1) % PER) < HOLD) && !exp_bit(d, pr, (c - 1) / PER);
         e_busy = (c < last);
         e_done = (c == last);
         if (pull != e_pull && bad_p < 0) begin bad_p = c; ap = int'(pull); ep = int'(e_pull); end
         if (busy != e_busy && bad_b < 0) begin bad_b = c; ab = int'(busy); eb = int'(e_busy); end
         if (done != e_done && bad_d < 0) begin bad_d = c; ad = int'(done); ed = int'(e_done); end
         if (c == inject) begin
            start = 1'b1;
            data  = 8'($urandom);
            pair  = 1'($urandom);
         end
      end
      // R3 R4 R5 R6: bit order, levels and timing of the pull-down
      chk(bad_p < 0, {tag, " R3/R4/R5/R6 pull waveform"}, ap, ep);
      // R7 R8: busy window, not extended by a start while busy
      chk(bad_b < 0, {tag, " R7/R8 busy window"}, ab, eb);
      // R7: single done pulse at the end
      chk(bad_d < 0, {tag, " R7 done pulse"}, ad, ed);
   endtask

   task automatic run_stall();
      bit bad = 1'b0;
      int seen = 0;
      @(negedge clk);
      peer_low = 1'b1;
      repeat (5) @(negedge clk);
      data = 8'h35; pair = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pull || !busy || done) bad = 1'b1;
      end
      // R2: held-low wire stalls without any pull
      chk(!bad, "R2 stall while wire low", int'(pull), 0);
      peer_low = 1'b0;
      @(negedge clk);
      chk(!pull, "R9 no pull one edge after release", int'(pull), 0);
      @(negedge clk);
      chk(!pull, "R9 no pull two edges after release", int'(pull), 0);
      @(negedge clk);
      chk(pull, "R9 pull after sync latency", int'(pull), 1);
      for (int i = 0; i < 200 && !done; i++) begin
         @(negedge clk);
         if (done) seen = 1;
      end
      chk(seen == 1, "R7 done after stalled transfer", seen, 1);
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!pull, "R1 pull in reset", int'(pull), 0);
      chk(!busy, "R1 busy in reset", int'(busy), 0);
      chk(!done, "R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pull && !busy && !done, "R1 idle after reset",
          int'({pull, busy, done}), 0);

      run_xfer(8'h0A, 1'b0, -1, "nibble 1010");
      run_xfer(8'hF6, 1'b0, -1, "nibble low bits only");
      run_xfer(8'h5C, 1'b1, -1, "pair 5C");
      run_xfer(8'h00, 1'b1, -1, "pair all zero");
      run_xfer(8'hFF, 1'b1, -1, "pair all one");
      run_xfer(8'h81, 1'b1, 20, "pair start while busy");
      run_xfer(8'h07, 1'b0, 60, "nibble start near end");
      run_stall();

      for (int n = 0; n < 30; n++) begin
         logic [7:0] d = 8'($urandom);
         bit pr = 1'($urandom);
         int last = (pr ? 8 : 4) * PER;
         int inj = (($urandom % 3) == 0) ? 1 + int'($urandom % (last - 3)) : -1;
         run_xfer(d, pr, inj, "random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule